// File: doc/BRIEF.md
# Memory self-test sequencer

This block tests a single-port synchronous RAM in place. After a one-cycle start pulse it runs a fixed series of test phases against the RAM and gives a verdict. The data bus is proven first, at a single location. Next, every address is shown to select a distinct cell. Then each bit of every cell is made to hold both values. Last, the whole array is filled from a pseudo-random generator under three seeds and read back. The sequencer stops at the first wrong read. It then reports the failing phase, the address, the expected word and the word that came back.

The RAM answers a read one cycle after the request. The sequencer issues exactly one RAM operation per cycle, with no gaps, from the cycle after start until the last read. Each read is checked in the following cycle against a registered copy of the expected word. Done stays high after a run, with either pass or fail set, until the next start pulse clears the results.

Top module: `mbist_seq`

## Requirements
- R1: After reset, and until the first start pulse, done_o, pass_o and fail_o are low and neither ram_we_o nor ram_re_o is asserted.
- R2: A start pulse seen while idle begins a run in the next cycle and clears done_o, pass_o and fail_o. A start pulse during a run is ignored. Once set, done_o stays high until the next start pulse.
- R3: The data-bus phase uses only address BUS_ADDR and its partner BUS_ADDR with bit 0 inverted. It first steps a single 1 from bit 0 to bit DW-1 (phase code 1). It then steps a single 0 from bit 0 to bit DW-1 (phase code 2). Each step takes three cycles: write the value to BUS_ADDR, write its bitwise complement to the partner address, then read BUS_ADDR.
- R4: The address phase (code 3) writes every location in ascending order, with the low DW bits of its own address as data. It then reads every location in ascending order.
- R5: The cell phase (code 4) first writes the alternating word with bit 0 set (0x55 for 8 bits) to all locations in ascending order. Then, for each address in turn, it reads the address and writes the inverted word (0xAA) there in the next cycle. A final ascending pass reads every location.
- R6: The random phase (code 5) runs three times, with SEED0, SEED1 and SEED2 in that order. Each run writes all locations in ascending order, then reads all of them in ascending order. The word for address k is the seed stepped k times by s -> (s >> 1) XOR (s[0] ? LFSR_TAPS : 0). LFSR_TAPS defaults to 0xB8.
- R7: Operations follow R3, R4, R5, R6 in that order, one per cycle with no idle cycle between them. ram_we_o and ram_re_o are never high together.
- R8: Read data is taken one cycle after the read request. At the first mismatch the sequencer issues no further operation after the current cycle. done_o and fail_o rise at the clock edge that ends the cycle in which the bad data returned. fail_phase_o, fail_addr_o, fail_exp_o and fail_act_o then hold the phase code, the read address, the expected word and the returned word.
- R9: If every read matches, done_o and pass_o rise at the edge that ends the cycle after the final read. Whenever done_o is high, exactly one of pass_o and fail_o is high.
- R10: Suppose the RAM returns the value last driven on the write bus rather than stored data. The run then fails in phase code 1 at BUS_ADDR, expecting 1 and receiving its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a run |
| done_o | output | 1 | Run finished; held until next start |
| pass_o | output | 1 | All phases matched |
| fail_o | output | 1 | A read mismatched |
| fail_phase_o | output | 3 | Phase code of the first mismatch |
| fail_addr_o | output | AW | Address of the first mismatch |
| fail_exp_o | output | DW | Expected word at the first mismatch |
| fail_act_o | output | DW | Returned word at the first mismatch |
| ram_addr_o | output | AW | RAM address |
| ram_wdata_o | output | DW | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM read enable |
| ram_rdata_i | input | DW | RAM read data, one cycle after ram_re_o |

## Verification
A corrupted counter or state register shows up at the RAM pins in the very cycle it takes effect. The bench compares every issued operation with a behavioural list of the expected operation stream, so a skipped step, a wrong address or a wrong pattern fails within one clock. A fault in the compare or capture path instead shows up in the verdict. The bench replays the stream against a fault model of the RAM to predict the exact cycle of done, the phase code, the address and both data words. Faults are modelled as a floating bus, a stuck bit, an aliased address line and a value-sensitive cell, and each is aimed so that it first trips a different phase.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [2:0] {
    PH_NONE  = 3'd0,
    PH_WALK1 = 3'd1,
    PH_WALK0 = 3'd2,
    PH_ADDR  = 3'd3,
    PH_CELL  = 3'd4,
    PH_RAND  = 3'd5
  } phase_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BUS,
    ST_ADDR_W,
    ST_ADDR_R,
    ST_CELL_FILL,
    ST_CELL_RD,
    ST_CELL_WR,
    ST_CELL_CHK,
    ST_RND_W,
    ST_RND_R,
    ST_DRAIN
  } state_e;

endpackage

// File: rtl/mbist_lfsr.sv
module mbist_lfsr #(
  parameter int unsigned   DW    = 8,
  parameter logic [DW-1:0] TAPS  = DW'(8'hB8),
  parameter logic [DW-1:0] RESET = DW'(8'h01)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] seed_i,
  input  logic          step_i,
  output logic [DW-1:0] state_o
);

  logic [DW-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= RESET;
    else if (load_i)  state_q <= seed_i;
    else if (step_i)  state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
  end

  assign state_o = state_q;

  // A nonzero seed must never collapse to the all-zero lock-up state.
  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R6

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          chk_i,
  input  logic [DW-1:0] exp_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    phase_i,
  input  logic [DW-1:0] rdata_i,
  output logic          mis_o,
  output logic          fail_o,
  output logic [2:0]    phase_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] exp_o,
  output logic [DW-1:0] act_o
);

  logic          pend_q;
  logic [DW-1:0] pexp_q;
  logic [AW-1:0] paddr_q;
  logic [2:0]    pph_q;
  logic          fail_q;
  logic [2:0]    cph_q;
  logic [AW-1:0] caddr_q;
  logic [DW-1:0] cexp_q, cact_q;

  // Expected word travels one cycle alongside the read it belongs to.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      pexp_q  <= '0;
      paddr_q <= '0;
      pph_q   <= '0;
    end else begin
      pend_q  <= chk_i;
      pexp_q  <= exp_i;
      paddr_q <= addr_i;
      pph_q   <= phase_i;
    end
  end

  assign mis_o = pend_q && !fail_q && (rdata_i != pexp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q  <= 1'b0;
      cph_q   <= '0;
      caddr_q <= '0;
      cexp_q  <= '0;
      cact_q  <= '0;
    end else if (clr_i) begin
      fail_q  <= 1'b0;
      cph_q   <= '0;
      caddr_q <= '0;
      cexp_q  <= '0;
      cact_q  <= '0;
    end else if (mis_o) begin
      fail_q  <= 1'b1;
      cph_q   <= pph_q;
      caddr_q <= paddr_q;
      cexp_q  <= pexp_q;
      cact_q  <= rdata_i;
    end
  end

  assign fail_o  = fail_q;
  assign phase_o = cph_q;
  assign addr_o  = caddr_q;
  assign exp_o   = cexp_q;
  assign act_o   = cact_q;

  AST_FIRST_FAIL_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q && !clr_i |=> fail_q && $stable(caddr_q) && $stable(cexp_q) && $stable(cact_q)); // R8

  AST_CAPTURE_DIFFERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_q) |-> cexp_q != cact_q); // R8

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int unsigned   AW        = 8,
  parameter int unsigned   DW        = 8,
  parameter int unsigned   BUS_ADDR  = 0,
  parameter logic [DW-1:0] LFSR_TAPS = DW'(8'hB8),
  parameter logic [DW-1:0] SEED0     = DW'(8'h01),
  parameter logic [DW-1:0] SEED1     = DW'(8'hA5),
  parameter logic [DW-1:0] SEED2     = DW'(8'h3C)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic [2:0]    fail_phase_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [DW-1:0] fail_exp_o,
  output logic [DW-1:0] fail_act_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          ram_we_o,
  output logic          ram_re_o,
  input  logic [DW-1:0] ram_rdata_i
);

  function automatic logic [DW-1:0] alt_word();
    logic [DW-1:0] w;
    for (int i = 0; i < DW; i++) w[i] = (i % 2 == 0);
    return w;
  endfunction

  localparam int unsigned   BW       = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [AW-1:0] BA       = AW'(BUS_ADDR);
  localparam logic [AW-1:0] BA_ALT   = BA ^ AW'(1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);
  localparam logic [DW-1:0] PAT_A    = alt_word();
  localparam logic [DW-1:0] PAT_B    = ~PAT_A;

  function automatic logic [DW-1:0] seed_of(input logic [1:0] idx);
    case (idx)
      2'd0:    return SEED0;
      2'd1:    return SEED1;
      default: return SEED2;
    endcase
  endfunction

  state_e        state_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] bit_q;
  logic [1:0]    step_q;
  logic          zeros_q;
  logic [1:0]    seed_q;
  logic          done_q, pass_q;

  logic          op_we, op_re;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata, op_exp;
  logic [2:0]    op_phase;
  logic [DW-1:0] walk_val, rnd_val, lfsr_seed;
  logic          lfsr_load, lfsr_step, mis, last_addr, clr;

  assign last_addr = &addr_q;
  assign clr       = (state_q == ST_IDLE) && start_i;
  assign walk_val  = zeros_q ? ~({{(DW-1){1'b0}}, 1'b1} << bit_q)
                             :  ({{(DW-1){1'b0}}, 1'b1} << bit_q);

  always_comb begin
    op_we    = 1'b0;
    op_re    = 1'b0;
    op_addr  = addr_q;
    op_wdata = '0;
    op_exp   = '0;
    op_phase = PH_NONE;
    case (state_q)
      ST_BUS: begin
        op_phase = zeros_q ? PH_WALK0 : PH_WALK1;
        op_exp   = walk_val;
        case (step_q)
          2'd0:    begin op_we = 1'b1; op_addr = BA;     op_wdata = walk_val;  end
          2'd1:    begin op_we = 1'b1; op_addr = BA_ALT; op_wdata = ~walk_val; end
          default: begin op_re = 1'b1; op_addr = BA; end
        endcase
      end
      ST_ADDR_W:    begin op_we = 1'b1; op_wdata = DW'(addr_q); end
      ST_ADDR_R:    begin op_re = 1'b1; op_exp = DW'(addr_q); op_phase = PH_ADDR; end
      ST_CELL_FILL: begin op_we = 1'b1; op_wdata = PAT_A; end
      ST_CELL_RD:   begin op_re = 1'b1; op_exp = PAT_A; op_phase = PH_CELL; end
      ST_CELL_WR:   begin op_we = 1'b1; op_wdata = PAT_B; end
      ST_CELL_CHK:  begin op_re = 1'b1; op_exp = PAT_B; op_phase = PH_CELL; end
      ST_RND_W:     begin op_we = 1'b1; op_wdata = rnd_val; end
      ST_RND_R:     begin op_re = 1'b1; op_exp = rnd_val; op_phase = PH_RAND; end
      default: ;
    endcase
  end

  // Generator reloads at the last address of a pass so the next pass starts on the seed.
  always_comb begin
    lfsr_step = (state_q == ST_RND_W) || (state_q == ST_RND_R);
    lfsr_load = last_addr && ((state_q == ST_CELL_CHK) || (state_q == ST_RND_W) ||
                              ((state_q == ST_RND_R) && (seed_q != 2'd2)));
    case (state_q)
      ST_CELL_CHK: lfsr_seed = seed_of(2'd0);
      ST_RND_W:    lfsr_seed = seed_of(seed_q);
      default:     lfsr_seed = seed_of(seed_q + 2'd1);
    endcase
  end

  mbist_lfsr #(.DW(DW), .TAPS(LFSR_TAPS), .RESET(SEED0)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (lfsr_load),
    .seed_i (lfsr_seed),
    .step_i (lfsr_step),
    .state_o(rnd_val)
  );

  mbist_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .chk_i  (op_re),
    .exp_i  (op_exp),
    .addr_i (op_addr),
    .phase_i(op_phase),
    .rdata_i(ram_rdata_i),
    .mis_o  (mis),
    .fail_o (fail_o),
    .phase_o(fail_phase_o),
    .addr_o (fail_addr_o),
    .exp_o  (fail_exp_o),
    .act_o  (fail_act_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      bit_q   <= '0;
      step_q  <= '0;
      zeros_q <= 1'b0;
      seed_q  <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_q <= ST_BUS;
        addr_q  <= '0;
        bit_q   <= '0;
        step_q  <= '0;
        zeros_q <= 1'b0;
        seed_q  <= '0;
        done_q  <= 1'b0;
        pass_q  <= 1'b0;
      end
    end else if (mis) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_BUS: begin
          if (step_q == 2'd2) begin
            step_q <= '0;
            if (bit_q == BIT_LAST) begin
              bit_q <= '0;
              if (zeros_q) state_q <= ST_ADDR_W;
              else         zeros_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            step_q <= step_q + 2'd1;
          end
        end
        ST_ADDR_W: begin
          addr_q <= addr_q + 1'b1;
          if (last_addr) state_q <= ST_ADDR_R;
        end
        ST_ADDR_R: begin
          addr_q <= addr_q + 1'b1;
          if (last_addr) state_q <= ST_CELL_FILL;
        end
        ST_CELL_FILL: begin
          addr_q <= addr_q + 1'b1;
          if (last_addr) state_q <= ST_CELL_RD;
        end
        ST_CELL_RD: state_q <= ST_CELL_WR;
        ST_CELL_WR: begin
          addr_q  <= addr_q + 1'b1;
          state_q <= last_addr ? ST_CELL_CHK : ST_CELL_RD;
        end
        ST_CELL_CHK: begin
          addr_q <= addr_q + 1'b1;
          if (last_addr) state_q <= ST_RND_W;
        end
        ST_RND_W: begin
          addr_q <= addr_q + 1'b1;
          if (last_addr) state_q <= ST_RND_R;
        end
        ST_RND_R: begin
          addr_q <= addr_q + 1'b1;
          if (last_addr) begin
            if (seed_q == 2'd2) begin
              state_q <= ST_DRAIN;
            end else begin
              seed_q  <= seed_q + 2'd1;
              state_q <= ST_RND_W;
            end
          end
        end
        ST_DRAIN: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          pass_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign ram_addr_o  = op_addr;
  assign ram_wdata_o = op_wdata;
  assign ram_we_o    = op_we;
  assign ram_re_o    = op_re;

  AST_SINGLE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && ram_re_o)); // R7

  AST_COMPL_BEFORE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o && (op_phase == PH_WALK1 || op_phase == PH_WALK0) |->
      $past(ram_we_o) && ($past(ram_addr_o) == BA_ALT) && ($past(ram_wdata_o) == ~op_exp)); // R3

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ram_we_o && !ram_re_o); // R8

  AST_DONE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o); // R2

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && start_i |=> !done_o && !pass_o && !fail_o); // R2

  AST_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({pass_o, fail_o})); // R9

  AST_FAIL_MEANS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o); // R8

endmodule

// File: tb/mbist_seq_tb.sv
module mbist_seq_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NW = 1 << AW;
  localparam logic [AW-1:0] BA = 8'h00;
  localparam logic [DW-1:0] TAPS = 8'hB8;

  typedef struct packed {
    logic          we;
    logic          re;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [2:0]    ph;
  } op_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, pass, fail, ram_we, ram_re;
  logic [2:0] fph;
  logic [AW-1:0] faddr, ram_addr;
  logic [DW-1:0] fexp, fact, ram_wdata;
  logic [DW-1:0] ram_rdata = '0;

  int nchk = 0, nfail = 0, cyc = 0;
  int mode_r = 0;
  logic mem_clr = 1'b0;
  logic mon_en = 1'b0;
  int mon_idx = 0;
  op_t ops[$];
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] bus_last = '0;

  always #2.5 clk = ~clk;

  mbist_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .done_o(done), .pass_o(pass), .fail_o(fail),
    .fail_phase_o(fph), .fail_addr_o(faddr), .fail_exp_o(fexp), .fail_act_o(fact),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_we_o(ram_we), .ram_re_o(ram_re),
    .ram_rdata_i(ram_rdata)
  );

  // Fault models: 1 floating bus, 2 stuck-at-0 bit 3 at 0x37,
  // 3 address bit 7 lost, 4 cell 0x10 flips bit 0 on values other than 0x55/0xAA/0x10.
  function automatic int idx_of(int m, logic [AW-1:0] a);
    return (m == 3) ? int'(a & 8'h7F) : int'(a);
  endfunction

  function automatic logic [DW-1:0] store_of(int m, logic [AW-1:0] a, logic [DW-1:0] d);
    if (m == 2 && a == 8'h37) return d & ~8'h08;
    if (m == 4 && a == 8'h10 && d != 8'h55 && d != 8'hAA && d != 8'h10) return d ^ 8'h01;
    return d;
  endfunction

  function automatic logic [DW-1:0] lfsr_next(logic [DW-1:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : 8'h00);
  endfunction

  always @(posedge clk) begin
    if (mem_clr) begin
      for (int i = 0; i < NW; i++) mem[i] <= '0;
      bus_last <= '0;
    end else begin
      if (ram_we) begin
        mem[idx_of(mode_r, ram_addr)] <= store_of(mode_r, ram_addr, ram_wdata);
        bus_last <= ram_wdata;
      end
      if (ram_re) ram_rdata <= (mode_r == 1) ? bus_last : mem[idx_of(mode_r, ram_addr)];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic op_t mk(logic we, logic re, logic [AW-1:0] a, logic [DW-1:0] d, logic [2:0] p);
    op_t o;
    o.we = we; o.re = re; o.addr = a; o.data = d; o.ph = p;
    return o;
  endfunction

  task automatic build_ops();
    logic [DW-1:0] seeds [3];
    logic [DW-1:0] v, s;
    seeds[0] = 8'h01; seeds[1] = 8'hA5; seeds[2] = 8'h3C;
    ops.delete();
    for (int z = 0; z < 2; z++)
      for (int i = 0; i < DW; i++) begin
        v = (z == 0) ? (8'h01 << i) : ~(8'h01 << i);
        ops.push_back(mk(1, 0, BA, v, 0));
        ops.push_back(mk(1, 0, BA ^ 8'h01, ~v, 0));
        ops.push_back(mk(0, 1, BA, v, (z == 0) ? 3'd1 : 3'd2));
      end
    for (int a = 0; a < NW; a++) ops.push_back(mk(1, 0, AW'(a), DW'(a), 0));
    for (int a = 0; a < NW; a++) ops.push_back(mk(0, 1, AW'(a), DW'(a), 3'd3));
    for (int a = 0; a < NW; a++) ops.push_back(mk(1, 0, AW'(a), 8'h55, 0));
    for (int a = 0; a < NW; a++) begin
      ops.push_back(mk(0, 1, AW'(a), 8'h55, 3'd4));
      ops.push_back(mk(1, 0, AW'(a), 8'hAA, 0));
    end
    for (int a = 0; a < NW; a++) ops.push_back(mk(0, 1, AW'(a), 8'hAA, 3'd4));
    for (int k = 0; k < 3; k++) begin
      s = seeds[k];
      for (int a = 0; a < NW; a++) begin ops.push_back(mk(1, 0, AW'(a), s, 0)); s = lfsr_next(s); end
      s = seeds[k];
      for (int a = 0; a < NW; a++) begin ops.push_back(mk(0, 1, AW'(a), s, 3'd5)); s = lfsr_next(s); end
    end
  endtask

  // Replays the expected stream on a faulty RAM model to find the first bad read.
  task automatic predict(input int m, output int fidx, output logic [2:0] p,
                         output logic [AW-1:0] a, output logic [DW-1:0] e, output logic [DW-1:0] g);
    logic [DW-1:0] pm [NW];
    logic [DW-1:0] pb, got;
    for (int i = 0; i < NW; i++) pm[i] = '0;
    pb = '0; fidx = 0; p = '0; a = '0; e = '0; g = '0;
    for (int k = 0; k < ops.size(); k++) begin
      if (ops[k].we) begin
        pm[idx_of(m, ops[k].addr)] = store_of(m, ops[k].addr, ops[k].data);
        pb = ops[k].data;
      end else begin
        got = (m == 1) ? pb : pm[idx_of(m, ops[k].addr)];
        if (got != ops[k].data) begin
          fidx = k + 1; p = ops[k].ph; a = ops[k].addr; e = ops[k].data; g = got;
          break;
        end
      end
    end
  endtask

  function automatic string tag_of(logic [2:0] p);
    case (p)
      3'd1, 3'd2: return "R3";
      3'd3:       return "R4";
      3'd4:       return "R5";
      3'd5:       return "R6";
      default:    return "R7";
    endcase
  endfunction

  // Per-clock comparison of the RAM pins against the expected stream.
  always @(negedge clk) begin
    if (mon_en) begin
      if (ram_we || ram_re) begin
        chk(!(ram_we && ram_re), "R7", "both enables", {ram_we, ram_re}, 2'b00);
        if (mon_idx >= ops.size()) begin
          chk(0, "R7", "operation after stream end", mon_idx, ops.size());
        end else begin
          chk(ram_we == ops[mon_idx].we && ram_re == ops[mon_idx].re &&
              ram_addr == ops[mon_idx].addr && (!ram_we || ram_wdata == ops[mon_idx].data),
              ops[mon_idx].re ? tag_of(ops[mon_idx].ph) : "R7", "operation",
              {ram_we, ram_re, ram_addr, ram_wdata},
              {ops[mon_idx].we, ops[mon_idx].re, ops[mon_idx].addr,
               ops[mon_idx].we ? ops[mon_idx].data : ram_wdata});
        end
        mon_idx++;
      end else if (mon_idx < ops.size() && !done) begin
        chk(0, "R7", "idle cycle inside run", mon_idx, ops.size());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic run(input int m, input bit extra_start, input string tag);
    int fidx, idx, exp_done;
    logic [2:0] p;
    logic [AW-1:0] a;
    logic [DW-1:0] e, g;
    mode_r = m;
    @(negedge clk); mem_clr = 1'b1;
    @(negedge clk); mem_clr = 1'b0;
    predict(m, fidx, p, a, e, g);
    mon_idx = 0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    mon_en = 1'b1;
    idx = 1;
    chk(!done && !pass && !fail, "R2", "results cleared by start", {done, pass, fail}, 3'b000);
    while (!done && idx < 20000) begin
      @(negedge clk);
      idx++;
      if (extra_start && idx == 100) start = 1'b1;
      if (extra_start && idx == 101) start = 1'b0;
    end
    mon_en = 1'b0;
    exp_done = (fidx == 0) ? ops.size() + 2 : fidx + 2;
    chk(idx == exp_done, (fidx == 0) ? "R9" : "R8", "done cycle", idx, exp_done);
    chk(pass == (fidx == 0) && fail == (fidx != 0), (fidx == 0) ? "R9" : tag,
        "verdict", {pass, fail}, {fidx == 0, fidx != 0});
    if (fidx != 0) begin
      chk(fph == p, "R8", "fail phase", fph, p);
      chk(faddr == a, "R8", "fail address", faddr, a);
      chk(fexp == e && fact == g, tag, "fail data", {fexp, fact}, {e, g});
    end
  endtask

  initial begin
    build_ops();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!done && !pass && !fail && !ram_we && !ram_re, "R1", "reset state",
          {done, pass, fail, ram_we, ram_re}, 5'b0);
    end

    run(0, 1'b1, "R2");
    repeat (10) @(negedge clk);
    chk(done && pass && !fail, "R2", "done held", {done, pass, fail}, 3'b110);

    run(1, 1'b0, "R10");
    chk(fph == 3'd1 && faddr == BA && fexp == 8'h01 && fact == 8'hFE, "R10",
        "floating bus verdict", {fph, faddr, fexp, fact}, {3'd1, BA, 8'h01, 8'hFE});
    run(2, 1'b0, "R5");
    chk(fph == 3'd4 && fact == 8'hA2, "R5", "stuck bit phase", {fph, fact}, {3'd4, 8'hA2});
    run(3, 1'b0, "R4");
    chk(fph == 3'd3 && fexp == 8'h00 && fact == 8'h80, "R4", "alias phase",
        {fph, fexp, fact}, {3'd3, 8'h00, 8'h80});
    run(4, 1'b0, "R6");
    run(0, 1'b0, "R9");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule